// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Unit

This unit turns a load or store request from a processor's execute stage into a request on a 32-bit data memory port. It adds a sign-extended 16-bit displacement to a 32-bit base value to form a byte address. From that address it drives a word address, a four-bit lane write mask, write data steered into the right lanes, and a read strobe. Bytes are numbered big-endian: the lowest byte address of a word is its most significant byte.

The request is registered once. The memory-side outputs appear one cycle after the request is presented. The memory is expected to return read data combinationally from the registered word address. In that same cycle the unit delivers the load result, taking either the whole word or the selected byte sign-extended to 32 bits.

Word accesses must be 4-byte aligned. A misaligned word access raises a flag and suppresses both the write mask and the read strobe, so memory is never touched. Byte accesses may use any address.

Top module: `lsu_byte_lane`

## Requirements
- R1: While reset is held, and in the cycle after it is released with no request, `mem_be` is 0, `mem_rd` is 0, `misalign` is 0 and `load_data` is 0.
- R2: One cycle after a request, `mem_addr` equals base + sign-extended offset, computed modulo 2^32, with bits 1:0 cleared.
- R3: The operation encoding is `req_op` 0 for word load, 1 for word store, 2 for byte load and 3 for byte store. An aligned word store gives `mem_be` = 4'b1111 and `mem_wdata` = `store_data` one cycle later, with `mem_rd` at 0.
- R4: A byte store gives a one-hot `mem_be`, with bit 3 for address bits 1:0 = 0 down to bit 0 for address bits 1:0 = 3. `mem_wdata` holds `store_data[7:0]` copied into all four lanes.
- R5: An aligned word load gives `mem_rd` = 1 and `mem_be` = 0 one cycle later. In that cycle `load_data` equals `mem_rdata`.
- R6: A byte load selects lane bits 31:24 for address bits 1:0 = 0, down to bits 7:0 for 3. `load_data[7:0]` is that byte and bits 31:8 copy its bit 7.
- R7: A word access whose address bits 1:0 are nonzero gives `misalign` = 1, `mem_be` = 0, `mem_rd` = 0 and `load_data` = 0 one cycle later. Memory contents stay unchanged.
- R8: A byte access never raises `misalign`, for any address.
- R9: A cycle with `req_valid` low gives `mem_be` = 0, `mem_rd` = 0, `misalign` = 0 and `load_data` = 0 one cycle later.
- R10: A byte store changes only the addressed byte. A later word load of the same word returns the other three bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation: 0 word load, 1 word store, 2 byte load, 3 byte store |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed byte displacement |
| store_data | input | 32 | Store source register value |
| mem_addr | output | 32 | Word address to memory (bits 1:0 zero) |
| mem_be | output | 4 | Lane write enables, bit 3 = most significant byte |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rd | output | 1 | Read strobe |
| misalign | output | 1 | Misaligned word access flag |
| mem_rdata | input | 32 | Read data returned for `mem_addr` |
| load_data | output | 32 | Load result |

## Verification
A wrong lane index shows up at the ports one cycle after the request. It appears either as a mask bit at the mirrored position or as a byte taken from the wrong end of the word. A wrong write mask can also corrupt neighbouring bytes, which stays hidden until a later word load of that address. The bench therefore reads words back after byte stores and after suppressed misaligned stores. An error in address arithmetic or sign extension appears directly on `mem_addr` in the cycle after the request, and the negative-offset cases are aimed at it.

// File: rtl/lsu_bl_pkg.sv
package lsu_bl_pkg;

    localparam int WORD_W = 32;
    localparam int OFF_W  = 16;
    localparam int BYTE_W = 8;
    localparam int BYTES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(BYTES);

    typedef enum logic [1:0] {
        OP_LW = 2'd0,
        OP_SW = 2'd1,
        OP_LB = 2'd2,
        OP_SB = 2'd3
    } mem_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [BYTES-1:0]  be;
        logic [WORD_W-1:0] wdata;
        logic              rd;
        logic              misalign;
        logic [LANE_W-1:0] lane;
        logic              byte_op;
    } mem_req_t;

    function automatic logic op_is_store(input mem_op_e op);
        return op == OP_SW || op == OP_SB;
    endfunction

    function automatic logic op_is_byte(input mem_op_e op);
        return op == OP_LB || op == OP_SB;
    endfunction

    function automatic logic [WORD_W-1:0] sext_off(input logic [OFF_W-1:0] off);
        return {{(WORD_W-OFF_W){off[OFF_W-1]}}, off};
    endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_bl_pkg::*;
(
    input  logic [WORD_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  mem_op_e           op,
    output logic [WORD_W-1:0] eff_addr,
    output logic              misalign
);
    always_comb begin
        eff_addr = base + sext_off(offset);
        misalign = !op_is_byte(op) && (eff_addr[LANE_W-1:0] != '0);
    end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
    import lsu_bl_pkg::*;
(
    input  logic              valid,
    input  mem_op_e           op,
    input  logic [LANE_W-1:0] lane,
    input  logic              misalign,
    input  logic [WORD_W-1:0] store_data,
    output logic [BYTES-1:0]  be,
    output logic [WORD_W-1:0] wdata,
    output logic              rd
);
    logic [WORD_W-1:0] replicated;

    for (genvar g = 0; g < BYTES; g++) begin : g_rep
        assign replicated[g*BYTE_W +: BYTE_W] = store_data[BYTE_W-1:0];
    end

    always_comb begin
        be    = '0;
        wdata = op_is_byte(op) ? replicated : store_data;
        rd    = valid && !op_is_store(op) && !misalign;
        if (valid && op_is_store(op) && !misalign) begin
            if (op_is_byte(op))
                be[BYTES-1-int'(lane)] = 1'b1;
            else
                be = '1;
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_bl_pkg::*;
(
    input  logic [WORD_W-1:0] rdata,
    input  logic [LANE_W-1:0] lane,
    input  logic              byte_op,
    input  logic              rd,
    output logic [WORD_W-1:0] load_data
);
    logic [BYTE_W-1:0] lanes [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lanes[g] = rdata[WORD_W-1-g*BYTE_W -: BYTE_W];
    end

    logic [BYTE_W-1:0] sel;
    assign sel = lanes[lane];

    always_comb begin
        if (!rd)
            load_data = '0;
        else if (byte_op)
            load_data = {{(WORD_W-BYTE_W){sel[BYTE_W-1]}}, sel};
        else
            load_data = rdata;
    end
endmodule

// File: rtl/lsu_byte_lane.sv
module lsu_byte_lane
    import lsu_bl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [WORD_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic [WORD_W-1:0] store_data,
    output logic [WORD_W-1:0] mem_addr,
    output logic [BYTES-1:0]  mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              misalign,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] load_data
);
    localparam logic [WORD_W-1:0] WORD_MASK = ~WORD_W'((1 << LANE_W) - 1);

    mem_op_e           op;
    logic [WORD_W-1:0] ea;
    logic              mis_raw;
    mem_req_t          req_d, req_q;

    assign op = mem_op_e'(req_op);

    lsu_addr_gen u_addr (
        .base     (base),
        .offset   (offset),
        .op       (op),
        .eff_addr (ea),
        .misalign (mis_raw)
    );

    lsu_store_steer u_steer (
        .valid      (req_valid),
        .op         (op),
        .lane       (ea[LANE_W-1:0]),
        .misalign   (mis_raw),
        .store_data (store_data),
        .be         (req_d.be),
        .wdata      (req_d.wdata),
        .rd         (req_d.rd)
    );

    always_comb begin
        req_d.addr     = ea & WORD_MASK;
        req_d.misalign = req_valid && mis_raw;
        req_d.lane     = ea[LANE_W-1:0];
        req_d.byte_op  = op_is_byte(op);
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req_d;
    end

    assign mem_addr  = req_q.addr;
    assign mem_be    = req_q.be;
    assign mem_wdata = req_q.wdata;
    assign mem_rd    = req_q.rd;
    assign misalign  = req_q.misalign;

    lsu_load_extract u_extract (
        .rdata     (mem_rdata),
        .lane      (req_q.lane),
        .byte_op   (req_q.byte_op),
        .rd        (req_q.rd),
        .load_data (load_data)
    );

    // R2: registered word address follows the previous cycle's sum
    assert_word_addr_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (mem_addr == ($past(ea) & WORD_MASK)));

    // R4: byte store enables exactly one lane
    assert_byte_store_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd3) |=> ($countones(mem_be) == 1));

    // R6: byte load result is sign-extended
    assert_byte_sext_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && req_q.byte_op) |->
            (load_data[WORD_W-1:BYTE_W] == {(WORD_W-BYTE_W){load_data[BYTE_W-1]}}));

    // R7: a flagged access neither writes nor reads
    assert_misalign_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        misalign |-> (mem_be == '0 && !mem_rd));

    // R8: byte accesses are never flagged
    assert_byte_no_misalign_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op[1]) |=> !misalign);

    // R9: idle cycle produces no memory activity
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (mem_be == '0 && !mem_rd && !misalign));
endmodule

// File: tb/lsu_byte_lane_tb_top.sv
`timescale 1ns/1ps
module lsu_byte_lane_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] base = '0;
    logic [15:0] offset = '0;
    logic [31:0] store_data = '0;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_rd;
    logic        misalign;
    logic [31:0] mem_rdata;
    logic [31:0] load_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lsu_byte_lane dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .base(base), .offset(offset), .store_data(store_data),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .misalign(misalign), .mem_rdata(mem_rdata),
        .load_data(load_data)
    );

    // simple word memory, 16 words
    logic [31:0] mem    [16];
    logic [31:0] shadow [16];

    assign mem_rdata = mem[mem_addr[5:2]];

    always @(posedge clk) begin
        for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sx16(input logic [15:0] o);
        return {{16{o[15]}}, o};
    endfunction

    function automatic logic [31:0] pick_byte(input logic [31:0] w, input logic [1:0] l);
        logic [7:0] b;
        b = w[31 - 8*int'(l) -: 8];
        return {{24{b[7]}}, b};
    endfunction

    // one request, checked one cycle later; shadow updated for legal stores
    task automatic do_req(input logic [1:0] op, input logic [31:0] b,
                          input logic [15:0] o, input logic [31:0] sd);
        logic [31:0] ea;
        logic        is_byte, is_st, mis;
        logic [3:0]  exp_be;
        logic [31:0] exp_ld;
        ea      = b + sx16(o);
        is_byte = op[1];
        is_st   = op[0];
        mis     = !is_byte && (ea[1:0] != 2'b00);
        req_valid  = 1'b1;
        req_op     = op;
        base       = b;
        offset     = o;
        store_data = sd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 mem_addr", mem_addr, {ea[31:2], 2'b00});
        if (mis) begin
            chk("R7 misalign", {31'd0, misalign}, 32'd1);
            chk("R7 be/rd", {27'd0, mem_be, mem_rd}, 32'd0);
            chk("R7 load_data", load_data, 32'd0);
        end else if (is_st) begin
            exp_be = is_byte ? (4'b1000 >> ea[1:0]) : 4'b1111;
            if (is_byte) begin
                chk("R8 misalign", {31'd0, misalign}, 32'd0);
                chk("R4 be", {28'd0, mem_be}, {28'd0, exp_be});
                chk("R4 wdata", mem_wdata, {4{sd[7:0]}});
            end else begin
                chk("R3 be", {28'd0, mem_be}, {28'd0, exp_be});
                chk("R3 wdata", mem_wdata, sd);
                chk("R3 rd", {31'd0, mem_rd}, 32'd0);
            end
            for (int k = 0; k < 4; k++)
                if (exp_be[k]) shadow[ea[5:2]][8*k +: 8] = is_byte ? sd[7:0] : sd[8*k +: 8];
        end else begin
            exp_ld = is_byte ? pick_byte(shadow[ea[5:2]], ea[1:0]) : shadow[ea[5:2]];
            if (is_byte) begin
                chk("R8 misalign", {31'd0, misalign}, 32'd0);
                chk("R6 load_data", load_data, exp_ld);
            end else begin
                chk("R5 rd/be", {27'd0, mem_be, mem_rd}, 32'd1);
                chk("R5 load_data", load_data, exp_ld);
            end
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] ea, sd;
        logic [15:0] o;
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) begin
            mem[i]    = 32'h1357_9BDF ^ (i * 32'h0101_0101);
            shadow[i] = 32'h1357_9BDF ^ (i * 32'h0101_0101);
        end
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {26'd0, mem_be, mem_rd, misalign}, 32'd0);
        chk("R1 reset load_data", load_data, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {26'd0, mem_be, mem_rd, misalign}, 32'd0);

        // directed corners
        do_req(2'd1, 32'h0000_0010, 16'h0000, 32'hA1B2_C3D4);   // R3
        do_req(2'd0, 32'h0000_0014, 16'hFFFC, 32'h0);           // R5, negative offset
        for (int l = 0; l < 4; l++)                              // R4 every lane
            do_req(2'd3, 32'h0000_0020, 16'(l), 32'hFFFF_FF80 + 32'(l));
        do_req(2'd0, 32'h0000_0020, 16'h0000, 32'h0);           // R10 readback
        do_req(2'd3, 32'h0000_0031, 16'h0001, 32'h0000_005A);   // R10 single lane
        do_req(2'd0, 32'h0000_0030, 16'h0000, 32'h0);
        chk("R10 neighbours kept", load_data, shadow[12]);
        for (int l = 0; l < 4; l++)                              // R6 each lane
            do_req(2'd2, 32'h0000_0020, 16'(l), 32'h0);
        do_req(2'd1, 32'h0000_0012, 16'h0000, 32'hDEAD_BEEF);   // R7 store
        do_req(2'd0, 32'h0000_0010, 16'h0000, 32'h0);           // R7 memory untouched
        do_req(2'd0, 32'h0000_0007, 16'h0000, 32'h0);           // R7 load
        do_req(2'd2, 32'h0000_1003, 16'hF000, 32'h0);           // R8 large negative offset
        @(negedge clk);                                          // R9 idle
        chk("R9 idle", {26'd0, mem_be, mem_rd, misalign}, 32'd0);
        chk("R9 idle load_data", load_data, 32'd0);

        // constrained random
        for (int n = 0; n < 400; n++) begin
            ea = 32'($urandom_range(0, 63));
            o  = 16'($urandom);
            sd = $urandom;
            do_req(2'($urandom_range(0, 3)), ea - sx16(o), o, sd);
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk);
                chk("R9 random idle", {26'd0, mem_be, mem_rd, misalign}, 32'd0);
            end
        end
        for (int w = 0; w < 16; w++)                             // R10 final sweep
            do_req(2'd0, 32'(w * 4), 16'h0000, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule